// File: doc/BRIEF.md
# Eight-Region Memory Protection Configuration and Access Check

This block holds the programming state for up to eight memory protection regions and answers, combinationally, whether a given memory request is allowed. Software reaches it through a small word-addressed register port. A type register reports how many regions exist. A control register switches protection on and sets its policy. A selector register picks the region to program. One register carries a region's base address and another carries its size and attributes. Three further copies of the base/attribute pair sit at higher offsets, so several regions can be programmed in one run of back-to-back writes. A base write can also name its target region inline, which updates the selector.

The check side takes a request address together with its privilege, fetch, write and fault-context qualifiers. It finds the highest-numbered enabled region that covers the address and reports that region. If the request breaks the region's access or execute rules it raises a fault. A request that no region covers is either allowed through a privileged background map or faulted.

Top module: `prot_region_cfg`

## Requirements
- R1: After reset the control register, the selector and every region's base and attributes read as zero, so all regions are disabled.
- R2: Word 0 (offset 0x00) reads 0x0000_0800: the region count (8) sits in bits 15:8, and bits 23:16 and bit 0 read zero.
- R3: Word 1 (offset 0x04) is control. Bit 0 turns checking on. Bit 1 keeps checking active in the hard-fault/NMI context. Bit 2 allows privileged requests that hit no region. Only bits 2:0 are stored and read back, and no register changes while cfg_wr_en is low.
- R4: Word 2 (offset 0x08) is the region selector. Only bits 2:0 are stored and read back.
- R5: A write to a base word with bit 4 set and bits 3:0 below 8 writes base bits 31:5 into the region named by bits 3:0 and loads that number into the selector. A base word reads back as the selected region's base in bits 31:5, zero in bit 4 and the selector in bits 3:0.
- R6: A base write with bit 4 set and bits 3:0 in the range 8 to 15 ignores the inline number. It writes the region held in the selector and leaves the selector unchanged.
- R7: An attribute word writes the selected region. It stores execute-never in bit 28, access permission in 26:24, type/share/cache/buffer bits in 21:16, sub-region disables in 15:8, size in 5:1 and enable in bit 0. All other bits read zero (read mask 0x173F_FF3F).
- R8: The base/attribute pairs at offsets 0x14/0x18, 0x1C/0x20 and 0x24/0x28 act exactly like the pair at 0x0C/0x10.
- R9: When control bit 0 is clear, or when the request is in the hard-fault/NMI context and control bit 1 is clear, no fault is raised.
- R10: An enabled region with size field s of 4 or more covers 2^(s+1) bytes aligned on that size. Sub-region disable bit k removes the k-th eighth of the region from it. A region with s below 4 never matches.
- R11: chk_hit reports that some region matches, and chk_region names the highest-numbered matching region, which alone decides the outcome.
- R12: With checking on and no region matching, a request faults unless it is privileged and control bit 2 is set.
- R13: On a match, the permission codes work as follows. Code 0 or 4 denies everything. Code 1 allows privileged read/write only. Code 2 allows privileged read/write and user read. Code 3 allows everything. Code 5 allows privileged read only. Code 6 or 7 allows read for everyone. An instruction fetch counts as a read and also faults when execute-never is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register byte offset (bits 1:0 ignored) |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr, combinational |
| chk_addr | input | 32 | Request address to check |
| chk_priv | input | 1 | Request is privileged |
| chk_fetch | input | 1 | Request is an instruction fetch |
| chk_write | input | 1 | Request is a data write |
| chk_hfnmi | input | 1 | Request comes from the hard-fault/NMI context |
| chk_fault | output | 1 | Request is refused |
| chk_hit | output | 1 | Some enabled region matches chk_addr |
| chk_region | output | 3 | Highest-numbered matching region |

## Verification
A register write that reprograms a region and a check of a request against that same region can occur in the same cycle. The bench holds a request on the check port while it writes that region's attribute word. It compares the verdict in the cycle before the clock edge, which must follow the old settings, and again after the edge, which must follow the new ones. A behavioural model that updates only on the clock edge judges both cycles.

// File: rtl/prot_region_pkg.sv
package prot_region_pkg;

    // control register bit positions
    localparam int CTRL_ON  = 0;
    localparam int CTRL_HF  = 1;
    localparam int CTRL_BG  = 2;
    localparam int CTRL_W   = 3;

    // word indices inside the register window
    localparam logic [3:0] W_TYPE = 4'd0;
    localparam logic [3:0] W_CTRL = 4'd1;
    localparam logic [3:0] W_SEL  = 4'd2;
    localparam logic [3:0] W_PAIR_FIRST = 4'd3;
    localparam logic [3:0] W_PAIR_LAST  = 4'd10;

    localparam int OVR_FLAG_BIT = 4;
    localparam int MIN_SIZE     = 4;

    typedef struct packed {
        logic [26:0] base;
        logic        xn;
        logic [2:0]  ap;
        logic [5:0]  tscb;
        logic [7:0]  srd;
        logic [4:0]  size;
        logic        en;
    } region_t;

    function automatic logic ap_allows(input logic [2:0] ap,
                                       input logic       priv,
                                       input logic       wr);
        logic ok;
        unique case (ap)
            3'd1:    ok = priv;
            3'd2:    ok = priv | ~wr;
            3'd3:    ok = 1'b1;
            3'd5:    ok = priv & ~wr;
            3'd6,
            3'd7:    ok = ~wr;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/prot_region_regs.sv
module prot_region_regs
    import prot_region_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [5:0]                      addr,
    input  logic [31:0]                     wdata,
    output logic [31:0]                     rdata,
    output logic [CTRL_W-1:0]               ctrl,
    output logic [IDX_W-1:0]                sel,
    output region_t [NUM_REGIONS-1:0]       regions
);

    logic [3:0]              word;
    logic                    is_pair;
    logic                    is_base;
    logic                    is_attr;
    logic                    ovr_ok;
    logic [IDX_W-1:0]        tgt;
    logic [CTRL_W-1:0]       ctrl_q;
    logic [IDX_W-1:0]        sel_q;
    region_t [NUM_REGIONS-1:0] regions_q;
    region_t                 cur;

    assign word    = addr[5:2];
    assign is_pair = (word >= W_PAIR_FIRST) && (word <= W_PAIR_LAST);
    assign is_base = is_pair && word[0];
    assign is_attr = is_pair && !word[0];
    assign ovr_ok  = wdata[OVR_FLAG_BIT] && (32'(wdata[3:0]) < NUM_REGIONS);
    assign tgt     = ovr_ok ? wdata[IDX_W-1:0] : sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            sel_q  <= '0;
        end else if (wr_en) begin
            if (word == W_CTRL)
                ctrl_q <= wdata[CTRL_W-1:0];
            if (word == W_SEL)
                sel_q <= wdata[IDX_W-1:0];
            else if (is_base && ovr_ok)
                sel_q <= wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regions_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_REGIONS; i++) begin
                if (is_base && tgt == IDX_W'(i))
                    regions_q[i].base <= wdata[31:5];
                if (is_attr && sel_q == IDX_W'(i)) begin
                    regions_q[i].xn   <= wdata[28];
                    regions_q[i].ap   <= wdata[26:24];
                    regions_q[i].tscb <= wdata[21:16];
                    regions_q[i].srd  <= wdata[15:8];
                    regions_q[i].size <= wdata[5:1];
                    regions_q[i].en   <= wdata[0];
                end
            end
        end
    end

    assign cur = regions_q[sel_q];

    always_comb begin
        rdata = '0;
        if (word == W_TYPE)
            rdata = {16'd0, 8'(NUM_REGIONS), 8'd0};
        else if (word == W_CTRL)
            rdata = 32'(ctrl_q);
        else if (word == W_SEL)
            rdata = 32'(sel_q);
        else if (is_base)
            rdata = {cur.base, 1'b0, 4'(sel_q)};
        else if (is_attr)
            rdata = {3'd0, cur.xn, 1'b0, cur.ap, 2'd0, cur.tscb,
                     cur.srd, 2'd0, cur.size, cur.en};
    end

    assign ctrl    = ctrl_q;
    assign sel     = sel_q;
    assign regions = regions_q;

endmodule

// File: rtl/prot_region_match.sv
module prot_region_match
    import prot_region_pkg::*;
(
    input  region_t     region,
    input  logic [31:0] addr,
    output logic        hit
);

    logic [5:0]  span_log;
    logic [32:0] span;
    logic [32:0] span_m1;
    logic [31:0] low_mask;
    logic [31:0] base_full;
    logic        in_range;
    logic [4:0]  sub_shift;
    logic [31:0] shifted;
    logic [2:0]  sub_idx;
    logic        usable;

    assign span_log  = {1'b0, region.size} + 6'd1;
    assign span      = 33'd1 << span_log;
    assign span_m1   = span - 33'd1;
    assign low_mask  = span_m1[31:0];
    assign base_full = {region.base, 5'd0};
    assign in_range  = ((addr ^ base_full) & ~low_mask) == 32'd0;
    assign sub_shift = region.size - 5'd2;
    assign shifted   = addr >> sub_shift;
    assign sub_idx   = shifted[2:0];
    assign usable    = region.en && (region.size >= 5'(MIN_SIZE));
    assign hit       = usable && in_range && !region.srd[sub_idx];

endmodule

// File: rtl/prot_region_judge.sv
module prot_region_judge
    import prot_region_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic [NUM_REGIONS-1:0]     hits,
    input  region_t [NUM_REGIONS-1:0]  regions,
    input  logic [CTRL_W-1:0]          ctrl,
    input  logic                       priv,
    input  logic                       fetch,
    input  logic                       write,
    input  logic                       hfnmi,
    output logic                       fault,
    output logic                       hit,
    output logic [IDX_W-1:0]           region_idx
);

    region_t win;
    logic    bypass;
    logic    perm_ok;

    always_comb begin
        hit        = 1'b0;
        region_idx = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hits[i]) begin
                hit        = 1'b1;
                region_idx = IDX_W'(i);
            end
        end
    end

    assign win     = regions[region_idx];
    assign bypass  = !ctrl[CTRL_ON] || (hfnmi && !ctrl[CTRL_HF]);
    assign perm_ok = ap_allows(win.ap, priv, write) && !(fetch && win.xn);

    always_comb begin
        if (bypass)
            fault = 1'b0;
        else if (hit)
            fault = !perm_ok;
        else
            fault = !(priv && ctrl[CTRL_BG]);
    end

endmodule

// File: rtl/prot_region_cfg.sv
module prot_region_cfg
    import prot_region_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [5:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [31:0]       chk_addr,
    input  logic              chk_priv,
    input  logic              chk_fetch,
    input  logic              chk_write,
    input  logic              chk_hfnmi,
    output logic              chk_fault,
    output logic              chk_hit,
    output logic [IDX_W-1:0]  chk_region
);

    logic [CTRL_W-1:0]         ctrl_w;
    logic [IDX_W-1:0]          sel_w;
    region_t [NUM_REGIONS-1:0] regions_w;
    logic [NUM_REGIONS-1:0]    hits_w;

    prot_region_regs #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .ctrl    (ctrl_w),
        .sel     (sel_w),
        .regions (regions_w)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        prot_region_match u_match (
            .region (regions_w[g]),
            .addr   (chk_addr),
            .hit    (hits_w[g])
        );
    end

    prot_region_judge #(.NUM_REGIONS(NUM_REGIONS)) u_judge (
        .hits       (hits_w),
        .regions    (regions_w),
        .ctrl       (ctrl_w),
        .priv       (chk_priv),
        .fetch      (chk_fetch),
        .write      (chk_write),
        .hfnmi      (chk_hfnmi),
        .fault      (chk_fault),
        .hit        (chk_hit),
        .region_idx (chk_region)
    );

endmodule

// File: rtl/prot_region_chk.sv
module prot_region_chk
    import prot_region_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W = $clog2(NUM_REGIONS)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_wr_en,
    input logic [5:0]                cfg_addr,
    input logic [31:0]               cfg_wdata,
    input logic                      chk_priv,
    input logic                      chk_fetch,
    input logic                      chk_hfnmi,
    input logic                      chk_fault,
    input logic                      chk_hit,
    input logic [IDX_W-1:0]          chk_region,
    input logic [CTRL_W-1:0]         ctrl,
    input logic [IDX_W-1:0]          sel,
    input region_t [NUM_REGIONS-1:0] regions
);

    logic [3:0] word;
    logic       base_word;
    assign word      = cfg_addr[5:2];
    assign base_word = (word >= W_PAIR_FIRST) && (word <= W_PAIR_LAST) && word[0];

    assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl[CTRL_ON] || (chk_hfnmi && !ctrl[CTRL_HF])) |-> !chk_fault);

    assert_nohit_user_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CTRL_ON] && !chk_hfnmi && !chk_hit && !chk_priv) |-> chk_fault);

    assert_xn_fetch_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[CTRL_ON] && !chk_hfnmi && chk_hit && chk_fetch && regions[chk_region].xn)
        |-> chk_fault);

    assert_sel_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && word == W_SEL) |=> (sel == $past(cfg_wdata[IDX_W-1:0])));

    assert_ovr_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && base_word && cfg_wdata[OVR_FLAG_BIT] &&
         32'(cfg_wdata[3:0]) >= NUM_REGIONS) |=> $stable(sel));

    assert_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_en |=> ($stable(ctrl) && $stable(sel) && $stable(regions)));

endmodule

bind prot_region_cfg prot_region_chk #(.NUM_REGIONS(NUM_REGIONS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .chk_priv   (chk_priv),
    .chk_fetch  (chk_fetch),
    .chk_hfnmi  (chk_hfnmi),
    .chk_fault  (chk_fault),
    .chk_hit    (chk_hit),
    .chk_region (chk_region),
    .ctrl       (ctrl_w),
    .sel        (sel_w),
    .regions    (regions_w)
);

// File: tb/sim_prot_region_cfg.sv
`timescale 1ns/1ps
module sim_prot_region_cfg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] chk_addr = '0;
    logic        chk_priv = 1'b0;
    logic        chk_fetch = 1'b0;
    logic        chk_write = 1'b0;
    logic        chk_hfnmi = 1'b0;
    logic        chk_fault;
    logic        chk_hit;
    logic [2:0]  chk_region;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural model state
    logic [31:0] mb [8];
    logic [31:0] ma [8];
    logic [2:0]  m_ctrl = '0;
    logic [2:0]  m_sel = '0;
    localparam logic [31:0] ATTR_MASK = 32'h173F_FF3F;

    always #4 clk = ~clk;  // 125 MHz

    prot_region_cfg u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .chk_addr(chk_addr),
        .chk_priv(chk_priv), .chk_fetch(chk_fetch), .chk_write(chk_write),
        .chk_hfnmi(chk_hfnmi), .chk_fault(chk_fault), .chk_hit(chk_hit),
        .chk_region(chk_region)
    );

    initial begin
        for (int i = 0; i < 8; i++) begin mb[i] = '0; ma[i] = '0; end
    end

    function automatic logic [31:0] m_read(input logic [5:0] a);
        int w = int'(a) / 4;
        if (w == 0) return 32'h0000_0800;
        if (w == 1) return {29'd0, m_ctrl};
        if (w == 2) return {29'd0, m_sel};
        if (w >= 3 && w <= 10 && (w % 2) == 1) return mb[m_sel] | {28'd0, 1'b0, m_sel};
        if (w >= 4 && w <= 10 && (w % 2) == 0) return ma[m_sel];
        return 32'd0;
    endfunction

    function automatic bit m_allow(input int ap, input bit pv, input bit wr);
        if (ap == 3) return 1;
        if (ap == 0 || ap == 4) return 0;
        if (wr) return pv && (ap == 1 || ap == 2);
        if (pv) return 1;
        return (ap == 2 || ap == 6 || ap == 7);
    endfunction

    task automatic m_eval(input logic [31:0] a, input bit pv, fe, wr, hf,
                          output bit f, output bit h, output int rg);
        longint sz, sub;
        int s;
        rg = -1;
        for (int r = 0; r < 8; r++) begin
            s = int'(ma[r][5:1]);
            if (ma[r][0] && s >= 4) begin
                sz = longint'(1) << (s + 1);
                if ((longint'(a) / sz) == (longint'(mb[r]) / sz)) begin
                    sub = (longint'(a) % sz) / (sz / 8);
                    if (!ma[r][8 + int'(sub)]) rg = r;
                end
            end
        end
        h = (rg >= 0);
        if (!m_ctrl[0] || (hf && !m_ctrl[1])) f = 0;
        else if (rg < 0) f = !(pv && m_ctrl[2]);
        else if (fe && ma[rg][28]) f = 1;
        else f = !m_allow(int'(ma[rg][26:24]), pv, wr);
    endtask

    // model update on the clock edge
    always @(posedge clk) begin
        int w;
        w = int'(cfg_addr) / 4;
        if (!rst_n) begin
            m_ctrl = '0; m_sel = '0;
            for (int i = 0; i < 8; i++) begin mb[i] = '0; ma[i] = '0; end
        end else if (cfg_wr_en) begin
            if (w == 1) m_ctrl = cfg_wdata[2:0];
            else if (w == 2) m_sel = cfg_wdata[2:0];
            else if (w >= 3 && w <= 10 && (w % 2) == 1) begin
                if (cfg_wdata[4] && cfg_wdata[3:0] < 4'd8) m_sel = cfg_wdata[2:0];
                mb[m_sel] = cfg_wdata & 32'hFFFF_FFE0;
            end else if (w >= 4 && w <= 10) begin
                ma[m_sel] = cfg_wdata & ATTR_MASK;
            end
        end
    end

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        bit ef, eh;
        int er;
        if (rst_n && !done) begin
            check("rdata", cfg_rdata, m_read(cfg_addr));
            m_eval(chk_addr, chk_priv, chk_fetch, chk_write, chk_hfnmi, ef, eh, er);
            check("fault", {31'd0, chk_fault}, {31'd0, ef});
            check("hit", {31'd0, chk_hit}, {31'd0, eh});
            if (eh) check("region", {29'd0, chk_region}, 32'(er));
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #2;
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a);
        cfg_addr = a;
        @(posedge clk); #2;
    endtask

    task automatic acc(input logic [31:0] a, input bit pv, fe, wrt, hf);
        chk_addr = a; chk_priv = pv; chk_fetch = fe; chk_write = wrt; chk_hfnmi = hf;
        @(posedge clk); #2;
    endtask

    function automatic logic [31:0] attr(input bit xn, input int ap, input int srd,
                                         input int size, input bit en);
        return (32'(xn) << 28) | (32'(ap) << 24) | (32'(srd & 255) << 8)
             | (32'(size & 31) << 1) | 32'(en);
    endfunction

    task automatic program_region(input int idx, input logic [31:0] base, input logic [31:0] at);
        wr(6'h0C, base | 32'h10 | 32'(idx));
        wr(6'h10, at);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL %s watchdog: actual running expected finished", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: reset state of every register
        cur_req = "R1";
        rd(6'h04); rd(6'h08); rd(6'h0C); rd(6'h10); rd(6'h18);
        // R2: type word
        cur_req = "R2";
        rd(6'h00);
        // R3: control, only three bits kept
        cur_req = "R3";
        wr(6'h04, 32'hFFFF_FFFF); rd(6'h04);
        wr(6'h04, 32'h0); rd(6'h04);
        // R4: selector
        cur_req = "R4";
        wr(6'h08, 32'd5); rd(6'h08);
        wr(6'h08, 32'hFF); rd(6'h08);
        // R5: inline region choice
        cur_req = "R5";
        wr(6'h0C, 32'h2000_0011); rd(6'h08); rd(6'h0C);
        // R6: out-of-range inline choice ignored
        cur_req = "R6";
        wr(6'h08, 32'd2);
        wr(6'h0C, 32'h3000_001A); rd(6'h08); rd(6'h0C);
        wr(6'h08, 32'd1); rd(6'h0C);
        // R7: attribute layout
        cur_req = "R7";
        wr(6'h08, 32'd2);
        wr(6'h10, 32'hFFFF_FFFF); rd(6'h10);
        // R8: alias pairs in one burst
        cur_req = "R8";
        wr(6'h14, 32'h4000_0013); wr(6'h18, attr(0, 1, 0, 19, 1));
        wr(6'h1C, 32'h5000_0014); wr(6'h20, attr(1, 3, 0, 9, 0));
        wr(6'h24, 32'h6000_0015); wr(6'h28, attr(0, 6, 8'hA5, 6, 0));
        rd(6'h24); rd(6'h28); rd(6'h1C); rd(6'h14);
        // region layout for the access checks
        cur_req = "R10";
        program_region(0, 32'h0000_0000, attr(0, 3, 8'h02, 15, 1));
        program_region(1, 32'h0000_4000, attr(1, 6, 0, 12, 1));
        program_region(2, 32'h2000_0000, attr(0, 3, 0, 3, 1));
        // R9: checking off and the fault-context bypass
        cur_req = "R9";
        wr(6'h04, 32'd0);
        acc(32'h5000_0000, 0, 0, 1, 0);
        wr(6'h04, 32'd1);
        acc(32'h5000_0000, 0, 0, 0, 1);
        wr(6'h04, 32'd3);
        acc(32'h5000_0000, 0, 0, 0, 1);
        wr(6'h04, 32'd1);
        // R10: size coverage, sub-region masking, too-small regions
        cur_req = "R10";
        acc(32'h0000_1000, 0, 0, 0, 0);
        acc(32'h0000_2100, 0, 0, 0, 0);
        acc(32'h0000_FFFC, 0, 0, 1, 0);
        acc(32'h0001_0000, 1, 0, 0, 0);
        acc(32'h2000_0004, 0, 0, 0, 0);
        acc(32'h400F_FFF0, 0, 0, 0, 0);
        // R11: overlap, higher region wins
        cur_req = "R11";
        acc(32'h0000_4100, 0, 0, 0, 0);
        acc(32'h0000_4100, 0, 0, 1, 0);
        acc(32'h0000_6000, 0, 0, 1, 0);
        // R12: background map
        cur_req = "R12";
        acc(32'h7000_0000, 1, 0, 0, 0);
        wr(6'h04, 32'd5);
        acc(32'h7000_0000, 1, 0, 1, 0);
        acc(32'h7000_0000, 0, 0, 0, 0);
        acc(32'h0000_2100, 1, 0, 0, 0);
        wr(6'h04, 32'd1);
        // R13: permission codes and execute-never
        cur_req = "R13";
        acc(32'h0000_4100, 1, 1, 0, 0);
        acc(32'h0000_0100, 0, 1, 0, 0);
        for (int ap = 0; ap < 8; ap++) begin
            program_region(3, 32'h4000_0000, attr(0, ap, 0, 19, 1));
            for (int k = 0; k < 4; k++) acc(32'h4000_0010, k[1], 0, k[0], 0);
        end
        // same-cycle write and check on region 3
        cur_req = "R11";
        program_region(3, 32'h4000_0000, attr(0, 1, 0, 19, 1));
        chk_addr = 32'h4000_0010; chk_priv = 1'b1; chk_write = 1'b0;
        wr(6'h10, attr(0, 1, 0, 19, 0));
        rd(6'h10);
        wr(6'h10, attr(0, 0, 0, 19, 1));
        rd(6'h10);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule